// File: doc/BRIEF.md
# Depuncturer and Correlation Branch Metric Unit

This block sits between a soft-decision demodulator and the add-compare-select stage of a rate-1/2 trellis decoder. Quantized received symbols arrive one at a time on a valid/ready stream. According to the selected puncture rate, the block puts back a null (zero-valued, erased) symbol in every slot the transmitter dropped. This rebuilds one symbol pair per trellis step. For that pair it produces four branch metrics, one for each expected pair of code bits. A smaller metric always means a closer match.

In soft mode a metric is a constant offset minus the correlation between the received pair and the antipodal image of the expected pair. This replaces a squared distance and needs only adds and negations. In hard mode each symbol is reduced to its sign bit, and the metric is the Hamming distance over the slots that are not erased. A synchronous frame-start pulse returns the puncture phase to the first step of the pattern, so the phase lines up with the decoder at each frame boundary.

Both streams follow valid/ready rules. An output is held stable while `out_valid` is high and `out_ready` is low. While the output register is full and not being drained, `in_ready` is low, so back-pressure from the metric consumer stalls the symbol source. `in_ready` does not depend on `in_valid`. `rate_sel` and `hard_mode` are plain control pins. They are expected to change only at frame boundaries.

Top module: `depunct_bm`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is low and the puncture phase is at step 0 with no held half-pair.
- R2: Soft metric j (j = 0..3) sits at `out_metric[j*MW +: MW]`, with MW = SW+2. Bit 1 of j is the expected bit of the first symbol and bit 0 of j is the expected bit of the second. A bit of 0 maps to +1 and a bit of 1 maps to -1. The metric equals 2^SW minus (r0*s0 + r1*s1), so it runs from 0 to 2^(SW+1).
- R3: With `rate_sel` = 01 (rate 2/3, period 2), step 0 takes two received symbols. Step 1 takes one symbol as the first of the pair, and a null is used as the second.
- R4: With `rate_sel` = 10 (rate 3/4, period 3), step 0 takes two symbols. Step 1 uses a null first and the received symbol second. Step 2 uses the received symbol first and a null second.
- R5: With `rate_sel` = 00 or 11 (rate 1/2), every step takes two consecutive received symbols with no null inserted.
- R6: With `hard_mode` high, a symbol whose sign bit is 1 decides bit 1, and any other symbol decides bit 0. Metric j is the count of non-erased slots whose decided bit differs from the expected bit.
- R7: A null symbol adds nothing to any metric. In soft mode it is worth zero, and in hard mode it is never counted as a mismatch.
- R8: While `out_valid` is high and `out_ready` is low, `out_metric` stays stable and `in_ready` is low. Otherwise `in_ready` is high.
- R9: A `frame_start` pulse with no symbol accepted returns the phase to step 0 and discards a held first symbol. The next two symbols form a fresh pair.
- R10: A symbol accepted in the same cycle as `frame_start` is handled as the first symbol of step 0 of the new frame.
- R11: The metrics for a step are valid on the clock edge after the edge that accepts the step's last received symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Returns the puncture phase to step 0 |
| rate_sel | input | 2 | 00/11 rate 1/2, 01 rate 2/3, 10 rate 3/4 |
| hard_mode | input | 1 | 1 selects Hamming metrics, 0 selects correlation |
| in_valid | input | 1 | Received symbol is valid |
| in_ready | output | 1 | Block accepts a symbol this cycle |
| in_sym | input | SW | Signed two's complement received symbol |
| out_valid | output | 1 | Branch metrics are valid |
| out_ready | input | 1 | Consumer takes the metrics this cycle |
| out_metric | output | 4*(SW+2) | Four unsigned branch metrics, metric j at bits j*MW upward |

## Verification
On every cycle the assertions check the output handshake: the metrics are held and the input is stalled while the output waits. They also check the one-cycle path from a completed pair to `out_valid`, and the algebraic shape of every loaded metric set. Soft metrics for complementary expected pairs sum to 2^(SW+1), and hard metrics for complementary pairs sum to the same count, which is at most two. Whether each slot of each puncture step gets a received symbol or a null, and whether a frame pulse restarts the phase correctly, shows only in the bench. It replays the rates, the modes and frame pulses placed mid-pair against its behavioural model, and adds known numerical vectors.

// File: rtl/depunct_bm_pkg.sv
package depunct_bm_pkg;

  typedef enum logic [1:0] {
    RATE_HALF    = 2'b00,
    RATE_TWO3RD  = 2'b01,
    RATE_THREE4  = 2'b10,
    RATE_HALF_B  = 2'b11
  } rate_e;

  // Number of trellis steps in one puncture period.
  function automatic logic [1:0] period_of(input rate_e r);
    case (r)
      RATE_TWO3RD: period_of = 2'd2;
      RATE_THREE4: period_of = 2'd3;
      default:     period_of = 2'd1;
    endcase
  endfunction

  // Slots carried on the channel for a step: bit 1 = first symbol, bit 0 = second.
  function automatic logic [1:0] keep_mask(input rate_e r, input logic [1:0] st);
    keep_mask = 2'b11;
    if (r == RATE_TWO3RD && st == 2'd1) keep_mask = 2'b10;
    if (r == RATE_THREE4 && st == 2'd1) keep_mask = 2'b01;
    if (r == RATE_THREE4 && st == 2'd2) keep_mask = 2'b10;
  endfunction

endpackage

// File: rtl/dp_phase.sv
module dp_phase
  import depunct_bm_pkg::*;
#(
  parameter int SW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start,
  input  logic                 fire,
  input  rate_e                rate,
  input  logic signed [SW-1:0] sym,
  output logic                 done,
  output logic signed [SW-1:0] r0,
  output logic signed [SW-1:0] r1,
  output logic                 n0,
  output logic                 n1
);

  logic [1:0]          step_q, step_eff, step_nxt;
  logic                half_q, half_eff;
  logic signed [SW-1:0] held_q;
  logic [1:0]          keep;
  logic [2:0]          step_inc;
  logic                last_sym;

  always_comb begin
    step_eff = frame_start ? 2'd0 : step_q;
    half_eff = frame_start ? 1'b0 : half_q;
    keep     = keep_mask(rate, step_eff);
    step_inc = {1'b0, step_eff} + 3'd1;
    step_nxt = (step_inc >= {1'b0, period_of(rate)}) ? 2'd0 : step_inc[1:0];

    last_sym = 1'b1;
    r0 = '0;
    r1 = '0;
    n0 = 1'b0;
    n1 = 1'b0;
    case (keep)
      2'b11: begin
        last_sym = half_eff;
        r0 = held_q;
        r1 = sym;
      end
      2'b10: begin
        r0 = sym;
        n1 = 1'b1;
      end
      2'b01: begin
        r1 = sym;
        n0 = 1'b1;
      end
      default: begin
        last_sym = 1'b0;
        n0 = 1'b1;
        n1 = 1'b1;
      end
    endcase
    done = fire & last_sym;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= '0;
      half_q <= 1'b0;
      held_q <= '0;
    end else if (fire) begin
      if (last_sym) begin
        step_q <= step_nxt;
        half_q <= 1'b0;
      end else begin
        step_q <= step_eff;
        half_q <= 1'b1;
        held_q <= sym;
      end
    end else if (frame_start) begin
      step_q <= '0;
      half_q <= 1'b0;
    end
  end

endmodule

// File: rtl/bm_corr.sv
module bm_corr #(
  parameter  int SW = 3,
  localparam int MW = SW + 2,
  localparam int NB = 4
) (
  input  logic                 hard,
  input  logic signed [SW-1:0] r0,
  input  logic signed [SW-1:0] r1,
  input  logic                 n0,
  input  logic                 n1,
  output logic [NB*MW-1:0]     metrics
);

  localparam int OFF = 1 << SW;

  for (genvar j = 0; j < NB; j++) begin : g_pair
    localparam logic EXP0 = 1'((j >> 1) & 1);
    localparam logic EXP1 = 1'(j & 1);
    int a0, a1, corr, hd;
    always_comb begin
      a0   = EXP0 ? -int'(r0) : int'(r0);
      a1   = EXP1 ? -int'(r1) : int'(r1);
      corr = a0 + a1;
      hd   = ((!n0 && (r0[SW-1] != EXP0)) ? 1 : 0)
           + ((!n1 && (r1[SW-1] != EXP1)) ? 1 : 0);
      metrics[j*MW +: MW] = hard ? MW'(hd) : MW'(OFF - corr);
    end
  end

endmodule

// File: rtl/depunct_bm.sv
module depunct_bm
  import depunct_bm_pkg::*;
#(
  parameter int SW = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_start,
  input  logic [1:0]             rate_sel,
  input  logic                   hard_mode,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic signed [SW-1:0]   in_sym,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [4*(SW+2)-1:0]    out_metric
);

  localparam int MW = SW + 2;
  localparam int NB = 4;

  logic                 fire;
  logic                 pair_done;
  logic signed [SW-1:0] pr0, pr1;
  logic                 pn0, pn1;
  logic [NB*MW-1:0]     bm_next;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  dp_phase #(.SW(SW)) u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .fire        (fire),
    .rate        (rate_e'(rate_sel)),
    .sym         (in_sym),
    .done        (pair_done),
    .r0          (pr0),
    .r1          (pr1),
    .n0          (pn0),
    .n1          (pn1)
  );

  bm_corr #(.SW(SW)) u_metric (
    .hard    (hard_mode),
    .r0      (pr0),
    .r1      (pr1),
    .n0      (pn0),
    .n1      (pn1),
    .metrics (bm_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_metric <= '0;
    end else if (pair_done) begin
      out_valid  <= 1'b1;
      out_metric <= bm_next;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

endmodule

// File: rtl/depunct_bm_chk.sv
module depunct_bm_chk #(
  parameter int SW = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [4*(SW+2)-1:0] out_metric,
  input logic               load,
  input logic               hard_mode
);

  localparam int MW = SW + 2;
  localparam int FULL = 2 << SW;

  int m0, m1, m2, m3;
  always_comb begin
    m0 = int'(out_metric[0*MW +: MW]);
    m1 = int'(out_metric[1*MW +: MW]);
    m2 = int'(out_metric[2*MW +: MW]);
    m3 = int'(out_metric[3*MW +: MW]);
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_metric));

  // R8
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R11
  load_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid);

  // R2
  soft_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load && !hard_mode |=> (m0 + m3 == FULL) && (m1 + m2 == FULL));

  // R6
  hard_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load && hard_mode |=> (m0 + m3 <= 2) && (m0 + m3 == m1 + m2));

endmodule

bind depunct_bm depunct_bm_chk #(.SW(SW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_metric (out_metric),
  .load       (pair_done),
  .hard_mode  (hard_mode)
);

// File: tb/depunct_bm_test.sv
`timescale 1ns/1ps
module depunct_bm_test;

  localparam int SW = 3;
  localparam int MW = SW + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic hard_mode = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [SW-1:0] in_sym = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [4*MW-1:0] out_metric;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";
  bit bp_on = 1'b0;
  logic [7:0] lfsr = 8'h5a;

  // behavioural model state
  logic [4*MW-1:0] q[$];
  int m_step = 0;
  int m_half = 0;
  int m_held = 0;

  always #5 clk = ~clk;

  depunct_bm #(.SW(SW)) uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .rate_sel(rate_sel),
    .hard_mode(hard_mode), .in_valid(in_valid), .in_ready(in_ready), .in_sym(in_sym),
    .out_valid(out_valid), .out_ready(out_ready), .out_metric(out_metric)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [4*MW-1:0] ref_metrics(input int r0, input int r1,
      input bit n0, input bit n1, input bit hard);
    logic [4*MW-1:0] v;
    v = '0;
    for (int j = 0; j < 4; j++) begin
      int e0 = (j >> 1) & 1;
      int e1 = j & 1;
      int m;
      if (hard) begin
        m = 0;
        if (!n0 && ((r0 < 0 ? 1 : 0) != e0)) m++;
        if (!n1 && ((r1 < 0 ? 1 : 0) != e1)) m++;
      end else begin
        m = (1 << SW) - ((e0 ? -1 : 1) * r0 + (e1 ? -1 : 1) * r1);
      end
      v[j*MW +: MW] = MW'(m);
    end
    return v;
  endfunction

  // Reference model, advanced at each rising edge from pre-edge values.
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      q.delete();
      m_step = 0;
      m_half = 0;
    end else begin
      bit p0, p1;
      int per;
      int s;
      chk(in_ready === ((q.size() == 0) || out_ready), "R8", "in_ready",
          64'(in_ready), 64'((q.size() == 0) || out_ready));
      if (out_valid && out_ready && q.size() > 0) void'(q.pop_front());
      if (frame_start) begin
        m_step = 0;
        m_half = 0;
      end
      if (in_valid && in_ready) begin
        s = int'(in_sym);
        per = (rate_sel == 2'b01) ? 2 : (rate_sel == 2'b10) ? 3 : 1;
        p0 = 1; p1 = 1;
        if (rate_sel == 2'b01 && m_step == 1) p1 = 0;
        if (rate_sel == 2'b10 && m_step == 1) p0 = 0;
        if (rate_sel == 2'b10 && m_step == 2) p1 = 0;
        if (p0 && p1 && m_half == 0) begin
          m_held = s;
          m_half = 1;
        end else begin
          if (p0 && p1) q.push_back(ref_metrics(m_held, s, 0, 0, hard_mode));
          else if (p0)  q.push_back(ref_metrics(s, 0, 0, 1, hard_mode));
          else          q.push_back(ref_metrics(0, s, 1, 0, hard_mode));
          m_half = 0;
          m_step++;
          if (m_step >= per) m_step = 0;
        end
      end
    end
  end

  // Output comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(out_valid === (q.size() > 0), cur_req, "out_valid",
          64'(out_valid), 64'(q.size() > 0));
      if (out_valid && q.size() > 0)
        chk(out_metric === q[0], cur_req, "out_metric", 64'(out_metric), 64'(q[0]));
    end
  end

  // Consumer back-pressure
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = bp_on ? lfsr[0] : 1'b1;
  end

  // Watchdog
  always @(posedge clk) begin
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic send(input int v);
    bit acc;
    in_valid = 1'b1;
    in_sym = SW'(v);
    acc = 1'b0;
    while (!acc) begin
      @(posedge clk);
      acc = in_ready;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_frame();
    in_valid = 1'b0;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  function automatic int mslice(input int j);
    return int'(out_metric[j*MW +: MW]);
  endfunction

  task automatic run_seq(input int n, input int seed);
    for (int i = 0; i < n; i++) send(((i * 5 + seed) % 8) - 4);
    idle(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid === 1'b0, "R1", "out_valid in reset", 64'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R1", "out_valid after reset", 64'(out_valid), 0);
    chk(in_ready === 1'b1, "R1", "in_ready after reset", 64'(in_ready), 1);

    // R2 / R11: known soft vector (3,-4) at rate 1/2
    cur_req = "R2";
    send(3);
    send(-4);
    chk(out_valid === 1'b1, "R11", "valid one edge after last symbol", 64'(out_valid), 1);
    chk(mslice(0) == 9,  "R2", "m0", 64'(mslice(0)), 9);
    chk(mslice(1) == 1,  "R2", "m1", 64'(mslice(1)), 1);
    chk(mslice(2) == 15, "R2", "m2", 64'(mslice(2)), 15);
    chk(mslice(3) == 7,  "R2", "m3", 64'(mslice(3)), 7);
    idle(2);

    cur_req = "R5";
    run_seq(14, 1);
    rate_sel = 2'b11;
    pulse_frame();
    run_seq(10, 3);

    cur_req = "R3";
    rate_sel = 2'b01;
    pulse_frame();
    run_seq(15, 2);

    cur_req = "R4";
    rate_sel = 2'b10;
    pulse_frame();
    run_seq(20, 6);

    // R7: rate 2/3 step 1 with null second symbol, soft
    cur_req = "R7";
    rate_sel = 2'b01;
    pulse_frame();
    send(1);
    send(1);
    send(3);
    chk(mslice(0) == 5 && mslice(1) == 5, "R7", "null slot soft m0/m1",
        64'({mslice(0), mslice(1)}), 64'({32'd5, 32'd5}));
    chk(mslice(2) == 11 && mslice(3) == 11, "R7", "null slot soft m2/m3",
        64'({mslice(2), mslice(3)}), 64'({32'd11, 32'd11}));
    idle(2);

    // R6: hard decision vector (-1,2) at rate 1/2
    cur_req = "R6";
    hard_mode = 1'b1;
    rate_sel = 2'b00;
    pulse_frame();
    send(-1);
    send(2);
    chk(mslice(2) == 0 && mslice(1) == 2, "R6", "hard m2/m1",
        64'({mslice(2), mslice(1)}), 64'({32'd0, 32'd2}));
    chk(mslice(0) == 1 && mslice(3) == 1, "R6", "hard m0/m3",
        64'({mslice(0), mslice(3)}), 64'({32'd1, 32'd1}));
    idle(2);
    run_seq(12, 5);
    cur_req = "R7";
    rate_sel = 2'b10;
    pulse_frame();
    run_seq(18, 0);
    hard_mode = 1'b0;

    // R8: random back-pressure
    cur_req = "R8";
    bp_on = 1'b1;
    pulse_frame();
    run_seq(45, 7);
    rate_sel = 2'b01;
    pulse_frame();
    run_seq(30, 4);
    bp_on = 1'b0;
    idle(4);

    // R9: frame pulse discards a held first symbol
    cur_req = "R9";
    rate_sel = 2'b00;
    pulse_frame();
    send(-4);
    pulse_frame();
    send(3);
    send(3);
    chk(out_valid === 1'b1 && mslice(0) == 2, "R9", "fresh pair m0",
        64'(mslice(0)), 2);
    idle(2);

    // R10: symbol together with frame_start starts step 0
    cur_req = "R10";
    rate_sel = 2'b10;
    pulse_frame();
    send(2);
    send(2);
    send(-3);
    frame_start = 1'b1;
    send(1);
    frame_start = 1'b0;
    send(2);
    chk(out_valid === 1'b1 && mslice(0) == 5, "R10", "new frame pair m0",
        64'(mslice(0)), 5);
    idle(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule